// File: doc/BRIEF.md
# Exception Vector and Cause Unit

This unit computes the state changes for a processor core when the core takes an exception. On a one-cycle take strobe it reads several inputs: the exception kind, the access direction, the current PC, whether the faulting instruction sits in a branch delay slot, and the present exception-level, error-level and bootstrap-vector status bits. It also reads the interrupt-vector select bit and the exception base register. From these it computes the handler PC, the saved restart PC, the branch-delay flag and the 5-bit cause code. It registers all of them in the same clock edge, together with the updated status bits.

A non-maskable interrupt or a soft reset takes a separate path. That path saves the restart PC into the error PC, raises error level and bootstrap vectors, and jumps to a fixed reset address. A translation fault also captures the faulting address and forms the page-table context and entry-high values. The surrounding register file reads these outputs once the strobe has been taken.

Top module: `exc_vector_unit`

## Requirements
- R1: The `kind` encoding is: 0 interrupt, 1 TLB modified, 2 TLB refill (no match), 3 TLB invalid, 4 address error, 5 instruction bus error, 6 data bus error, 7 syscall, 8 break, 9 reserved instruction, 10 coprocessor unusable, 11 overflow, 12 trap, 13 floating point, 14 watch, 15 machine check, 16 non-maskable interrupt, 17 soft reset. Kinds 0..15 are general exceptions. Their `cause_exc` codes are 0, 1, -, -, -, 6, 7, 8, 9, 10, 11, 12, 13, 15, 23 and 24 respectively.
- R2: For kinds 2, 3 and 4 the cause code depends on `is_write`. Kinds 2 and 3 give 3 on a write and 2 on a read. Kind 4 gives 5 on a write and 4 on a read.
- R3: For a general exception the vector base is `BOOT_BASE` (0xBFC00200) when `bev_in` is 1. Otherwise it is `ebase` with bits 9..0 cleared.
- R4: `vec_pc` is the vector base plus an offset. The offset is 0x200 for an interrupt with `iv_in`=1. It is 0x000 for a refill (kind 2) with `exl_in`=0. In all other cases it is 0x180.
- R5: A general exception with `exl_in`=0 sets `epc` and `cause_bd`. With `in_delay`=1 they become `pc`-4 and 1. Otherwise they become `pc` and 0. The exception also sets `st_exl`. `st_erl` and `st_bev` copy the inputs.
- R6: A general exception with `exl_in`=1 leaves `epc` and `cause_bd` unchanged.
- R7: Kinds 16 and 17 set `st_erl` and `st_bev` and write the delay-corrected PC to `err_pc`. They set `vec_pc` to `RESET_PC` (0xBFC00000). Kind 16 sets `st_nmi` and kind 17 sets `st_sr`. `epc` and `cause_exc` stay unchanged, and `cause_bd` is cleared when `exl_in`=0.
- R8: Kinds 1..4 load `fault_addr` into `badva`. `ctx` becomes {`ctx_base`, `fault_addr`[31:13], 4'b0000}. `ent_hi` becomes {`fault_addr`[31:13], 5'b0, `asid`}.
- R9: Kinds 0 and 5..17 leave `badva`, `ctx` and `ent_hi` unchanged.
- R10: With `take`=0, or with a kind of 18..31, no output register changes.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take | input | 1 | Take-exception strobe |
| kind | input | 5 | Exception kind (R1 encoding) |
| is_write | input | 1 | Faulting access was a store |
| pc | input | 32 | PC of the excepting instruction |
| in_delay | input | 1 | Instruction is in a branch delay slot |
| exl_in | input | 1 | Current exception-level bit |
| erl_in | input | 1 | Current error-level bit |
| bev_in | input | 1 | Current bootstrap-vector bit |
| iv_in | input | 1 | Interrupt-vector select bit |
| ebase | input | 32 | Exception base register |
| fault_addr | input | 32 | Faulting virtual address |
| asid | input | 8 | Current address-space identifier |
| ctx_base | input | 9 | Page-table base bits of the context register |
| vec_pc | output | 32 | Handler PC |
| epc | output | 32 | Exception restart PC |
| err_pc | output | 32 | Error restart PC |
| cause_bd | output | 1 | Branch-delay flag |
| cause_exc | output | 5 | Cause code |
| st_exl | output | 1 | Updated exception level |
| st_erl | output | 1 | Updated error level |
| st_bev | output | 1 | Updated bootstrap-vector bit |
| st_nmi | output | 1 | Non-maskable-interrupt flag |
| st_sr | output | 1 | Soft-reset flag |
| badva | output | 32 | Bad virtual address |
| ctx | output | 32 | Context register |
| ent_hi | output | 32 | Entry-high register |

## Verification
A TLB refill can take the refill-offset path, the fault-recording path and the restart-PC save in one edge. A refill taken with exception level already set must still record the fault address. It must also drop back to offset 0x180 and keep the old restart PC. The bench provokes this by first taking a delay-slot exception and then raising a refill with `exl_in`=1. It judges the result by comparing `epc` with the value observed before the strobe, while checking `vec_pc` and `cause_exc` against the table.

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [31:0] RESET_PC  = 32'hBFC0_0000,
  parameter int          KW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [KW-1:0] kind,
  input  logic          is_write,
  input  logic [31:0]   pc,
  input  logic          in_delay,
  input  logic          exl_in,
  input  logic          erl_in,
  input  logic          bev_in,
  input  logic          iv_in,
  input  logic [31:0]   ebase,
  input  logic [31:0]   fault_addr,
  input  logic [7:0]    asid,
  input  logic [8:0]    ctx_base,
  output logic [31:0]   vec_pc,
  output logic [31:0]   epc,
  output logic [31:0]   err_pc,
  output logic          cause_bd,
  output logic [4:0]    cause_exc,
  output logic          st_exl,
  output logic          st_erl,
  output logic          st_bev,
  output logic          st_nmi,
  output logic          st_sr,
  output logic [31:0]   badva,
  output logic [31:0]   ctx,
  output logic [31:0]   ent_hi
);
  localparam logic [KW-1:0] K_INT  = KW'(0);
  localparam logic [KW-1:0] K_MOD  = KW'(1);
  localparam logic [KW-1:0] K_MISS = KW'(2);
  localparam logic [KW-1:0] K_INV  = KW'(3);
  localparam logic [KW-1:0] K_ADR  = KW'(4);
  localparam logic [KW-1:0] K_NMI  = KW'(16);
  localparam logic [KW-1:0] K_SRST = KW'(17);

  logic [4:0]  code;
  logic [31:0] base, offs, restart;
  logic        general, nmi_like, fault;

  assign general  = kind < KW'(16);
  assign nmi_like = (kind == K_NMI) || (kind == K_SRST);
  assign fault    = (kind >= K_MOD) && (kind <= K_ADR);
  assign restart  = in_delay ? pc - 32'd4 : pc;
  assign base     = bev_in ? BOOT_BASE : {ebase[31:10], 10'b0};

  always_comb begin
    if (kind == K_INT && iv_in)         offs = 32'h200;
    else if (kind == K_MISS && !exl_in) offs = 32'h000;
    else                                offs = 32'h180;
  end

  always_comb begin
    case (kind)
      K_INT:   code = 5'd0;
      K_MOD:   code = 5'd1;
      K_MISS,
      K_INV:   code = is_write ? 5'd3 : 5'd2;
      K_ADR:   code = is_write ? 5'd5 : 5'd4;
      KW'(5):  code = 5'd6;
      KW'(6):  code = 5'd7;
      KW'(7):  code = 5'd8;
      KW'(8):  code = 5'd9;
      KW'(9):  code = 5'd10;
      KW'(10): code = 5'd11;
      KW'(11): code = 5'd12;
      KW'(12): code = 5'd13;
      KW'(13): code = 5'd15;
      KW'(14): code = 5'd23;
      KW'(15): code = 5'd24;
      default: code = cause_exc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_pc <= '0; epc <= '0; err_pc <= '0; cause_bd <= 1'b0; cause_exc <= '0;
      st_exl <= 1'b0; st_erl <= 1'b0; st_bev <= 1'b0; st_nmi <= 1'b0; st_sr <= 1'b0;
      badva <= '0; ctx <= '0; ent_hi <= '0;
    end else if (take) begin
      if (general) begin
        if (!exl_in) begin
          epc      <= restart;
          cause_bd <= in_delay;
        end
        st_exl    <= 1'b1;
        st_erl    <= erl_in;
        st_bev    <= bev_in;
        cause_exc <= code;
        vec_pc    <= base + offs;
        if (fault) begin
          badva  <= fault_addr;
          ctx    <= {ctx_base, fault_addr[31:13], 4'b0000};
          ent_hi <= {fault_addr[31:13], 5'b0, asid};
        end
      end else if (nmi_like) begin
        err_pc <= restart;
        st_exl <= exl_in;
        st_erl <= 1'b1;
        st_bev <= 1'b1;
        if (kind == K_NMI) st_nmi <= 1'b1;
        else               st_sr  <= 1'b1;
        if (!exl_in) cause_bd <= 1'b0;
        vec_pc <= RESET_PC;
      end
    end
  end
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        take,
  input logic [4:0]  kind,
  input logic        exl_in,
  input logic        bev_in,
  input logic [31:0] ebase,
  input logic [31:0] fault_addr,
  input logic [31:0] vec_pc,
  input logic [31:0] epc,
  input logic        cause_bd,
  input logic [4:0]  cause_exc,
  input logic        st_exl,
  input logic        st_erl,
  input logic        st_bev,
  input logic [31:0] badva
);
  AST_EXL_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    take && kind < 5'd16 |=> st_exl); // R5
  AST_EPC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    take && kind < 5'd16 && exl_in |=> $stable(epc) && $stable(cause_bd)); // R6
  AST_RESET_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    take && (kind == 5'd16 || kind == 5'd17) |=> vec_pc == 32'hBFC0_0000 && st_erl && st_bev); // R7
  AST_REFILL_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    take && kind == 5'd2 && !exl_in && !bev_in |=> vec_pc == {$past(ebase[31:10]), 10'h000}); // R4
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    take && kind >= 5'd1 && kind <= 5'd4 |=> badva == $past(fault_addr)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(vec_pc) && $stable(cause_exc) && $stable(epc)); // R10
endmodule

bind exc_vector_unit exc_vector_unit_chk u_chk (.*);

// File: tb/exc_vector_unit_bench.sv
module exc_vector_unit_bench;
  logic clk = 0, rst_n = 0, take = 0, is_write = 0, in_delay = 0;
  logic exl_in = 0, erl_in = 0, bev_in = 0, iv_in = 0;
  logic [4:0] kind = 0;
  logic [31:0] pc = 0, ebase = 32'h8000_1234, fault_addr = 0;
  logic [7:0] asid = 0;
  logic [8:0] ctx_base = 0;
  logic [31:0] vec_pc, epc, err_pc, badva, ctx, ent_hi;
  logic cause_bd, st_exl, st_erl, st_bev, st_nmi, st_sr;
  logic [4:0] cause_exc;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  exc_vector_unit u_exc_vector_unit (.*);

  // {kind, wr, dly, exl, bev, iv, pc, expected vec_pc, expected code}: R1 R2 R3 R4
  localparam logic [78:0] TBL [23] = '{
    {5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0040_0100, 32'h8000_1180, 5'd0},
    {5'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0040_0104, 32'h8000_1200, 5'd0},
    {5'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0040_0108, 32'h8000_1000, 5'd2},
    {5'd2, 1'b1,1'b0,1'b1,1'b0,1'b0, 32'h0040_010C, 32'h8000_1180, 5'd3},
    {5'd3, 1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0040_0110, 32'h8000_1180, 5'd3},
    {5'd3, 1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0040_0114, 32'hBFC0_0380, 5'd2},
    {5'd4, 1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0040_0118, 32'h8000_1180, 5'd5},
    {5'd4, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0040_011C, 32'h8000_1180, 5'd4},
    {5'd1, 1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0040_0120, 32'h8000_1180, 5'd1},
    {5'd5, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0040_0124, 32'h8000_1180, 5'd6},
    {5'd6, 1'b0,1'b1,1'b1,1'b0,1'b0, 32'h0040_0128, 32'h8000_1180, 5'd7},
    {5'd7, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0040_012C, 32'h8000_1180, 5'd8},
    {5'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0040_0130, 32'h8000_1180, 5'd9},
    {5'd9, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0040_0134, 32'h8000_1180, 5'd10},
    {5'd10,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0040_0138, 32'h8000_1180, 5'd11},
    {5'd11,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0040_013C, 32'h8000_1180, 5'd12},
    {5'd12,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0040_0140, 32'h8000_1180, 5'd13},
    {5'd13,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0040_0144, 32'h8000_1180, 5'd15},
    {5'd14,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0040_0148, 32'h8000_1180, 5'd23},
    {5'd15,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0040_014C, 32'h8000_1180, 5'd24},
    {5'd2, 1'b0,1'b1,1'b0,1'b1,1'b0, 32'h0040_0150, 32'hBFC0_0200, 5'd2},
    {5'd0, 1'b0,1'b0,1'b1,1'b1,1'b1, 32'h0040_0154, 32'hBFC0_0400, 5'd0},
    {5'd0, 1'b0,1'b0,1'b1,1'b0,1'b1, 32'h0040_0158, 32'h8000_1200, 5'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [4:0] k, input logic wr, input logic dly, input logic exl,
                      input logic bev, input logic iv, input logic [31:0] p);
    @(negedge clk);
    kind = k; is_write = wr; in_delay = dly; exl_in = exl; bev_in = bev; iv_in = iv; pc = p;
    take = 1;
    @(negedge clk);
    take = 0;
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] old_epc, old_bd, old_pc, old_code;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 vec_pc", vec_pc, 0); chk("R11 epc", epc, 0); chk("R11 err_pc", err_pc, 0);
    chk("R11 status", {27'b0, st_exl, st_erl, st_bev, st_nmi, st_sr}, 0);
    chk("R11 regs", badva | ctx | ent_hi | {26'b0, cause_bd, cause_exc}, 0);
    rst_n = 1;

    // R8 fault recording
    fault_addr = 32'h1234_5678; asid = 8'hA5; ctx_base = 9'h1FF;
    fire(5'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2000);
    chk("R8 badva", badva, 32'h1234_5678);
    chk("R8 ctx", ctx, 32'hFF89_1A20);
    chk("R8 ent_hi", ent_hi, 32'h1234_40A5);
    chk("R5 epc delay", epc, 32'h0000_1FFC);
    chk("R5 bd", {31'b0, cause_bd}, 1);

    // R9 non-fault kind leaves fault registers alone
    fault_addr = 32'hDEAD_0000; asid = 8'h11; ctx_base = 9'h001;
    fire(5'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_3000);
    chk("R9 badva", badva, 32'h1234_5678);
    chk("R9 ctx", ctx, 32'hFF89_1A20);
    chk("R9 ent_hi", ent_hi, 32'h1234_40A5);
    // R6 refill with exception level set, after a delay-slot save
    fire(5'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_4000);
    chk("R6 epc kept", epc, 32'h0000_1FFC);
    chk("R6 bd kept", {31'b0, cause_bd}, 1);
    chk("R4 refill exl vec", vec_pc, 32'h8000_1180);
    chk("R8 badva refill", badva, 32'hDEAD_0000);

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 23; i++) begin
      logic [78:0] r;
      r = TBL[i];
      old_epc = epc; old_bd = {31'b0, cause_bd};
      fire(r[78:74], r[73], r[72], r[71], r[70], r[69], r[68:37]);
      chk("R3/R4 vec_pc", vec_pc, r[36:5]);
      chk("R1/R2 code", {27'b0, cause_exc}, {27'b0, r[4:0]});
      chk("R5 st_exl", {31'b0, st_exl}, 1);
      chk("R5 st_bev", {31'b0, st_bev}, {31'b0, r[70]});
      if (!r[71]) begin
        chk("R5 epc", epc, r[72] ? r[68:37] - 32'd4 : r[68:37]);
        chk("R5 bd", {31'b0, cause_bd}, {31'b0, r[72]});
      end else begin
        chk("R6 epc", epc, old_epc);
        chk("R6 bd", {31'b0, cause_bd}, old_bd);
      end
    end

    // R7 non-maskable interrupt from delay slot; bd set first
    fire(5'd9, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_5000);
    old_epc = epc; old_code = {27'b0, cause_exc};
    fire(5'd16, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_6000);
    chk("R7 err_pc", err_pc, 32'h0000_5FFC);
    chk("R7 vec_pc", vec_pc, 32'hBFC0_0000);
    chk("R7 erl/bev/nmi/sr", {28'b0, st_erl, st_bev, st_nmi, st_sr}, 32'hE);
    chk("R7 epc kept", epc, old_epc);
    chk("R7 code kept", {27'b0, cause_exc}, old_code);
    chk("R7 bd cleared", {31'b0, cause_bd}, 0);
    fire(5'd17, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_7000);
    chk("R7 sr flag", {31'b0, st_sr}, 1);
    chk("R7 err_pc sr", err_pc, 32'h0000_7000);

    // R10 unknown kind and idle strobe
    old_pc = vec_pc; old_code = {27'b0, cause_exc}; old_epc = err_pc;
    fire(5'd20, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_8000);
    chk("R10 unknown vec_pc", vec_pc, old_pc);
    chk("R10 unknown code", {27'b0, cause_exc}, old_code);
    chk("R10 unknown err_pc", err_pc, old_epc);
    @(negedge clk); kind = 5'd0; pc = 32'h0000_9000;
    repeat (2) @(negedge clk);
    chk("R10 idle vec_pc", vec_pc, old_pc);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule